// File: doc/BRIEF.md
# Stoppable Clock Group Stop and Power-Down Controller

This block decides, for each output of a group of stoppable differential clocks, whether that output toggles, is parked at fixed levels, or is put in high impedance. Two asynchronous active-low request pins drive the decision: a stop request and a power-down request. Both pass through a synchronizer into the reference-clock domain. Two configuration bits choose the stopped state. One bit applies to the stop request and the other to power-down. A value of 1 means tristate and 0 means driven, with the true output low and the complement output high. A separate group of free-running enables, for the processor-side and peripheral-bus-side clocks, stays on whatever the requests do.

When power-down is released, the group is held stopped for a fixed resume window of `RESUME_CYC` reference cycles. The default is 1.8 ms at 250 MHz. The window is armed only by a power-down release, so nothing delays the group after reset. A stop release that arrives inside the window is honoured at the window's end, without extra delay. A configuration change that arrives inside the window is held and is picked up when the window closes. Each output switches only while its own source clock is low, so no shortened pulse reaches a pin.

Top module: `clk_stop_ctl`

## Requirements
- R1: After reset every output has `run_o`=1 and `hiz_o`=0, and every bit of `free_en_o` is 1.
- R2: While the stop request is active (`stop_req_n`=0) and the stop configuration bit is 0, every output stops driven: `run_o`=0, `hiz_o`=0, `true_o`=0, `comp_o`=1.
- R3: When both `cfg_stop_tri` and `cfg_pdn_tri` are 1, every output has `hiz_o`=1 while either request is active. It returns to `run_o`=1, `hiz_o`=0 once the requests and any resume window are over.
- R4: `free_en_o` stays all ones under every request and configuration.
- R5: A power-down release starts a window of exactly `RESUME_CYC` cycles. The window counter is loaded the cycle after the synchronized request falls, and no output resumes before the window has ended.
- R6: A stop release inside the resume window lets the outputs resume at the window's end, no later than the next low phase of each source clock.
- R7: A change of `cfg_stop_tri` or `cfg_pdn_tri` during the resume window has no effect on the outputs until the window ends, and it takes effect from then on.
- R8: Each request pin passes through a two-stage synchronizer. A change at a pin can first affect an output at the third rising clock edge after it.
- R9: `run_o[i]` and `hiz_o[i]` change only at a clock edge where `src_clk_i[i]` is 0. While running, `true_o[i]` follows `src_clk_i[i]` and `comp_o[i]` is its inverse.
- R10: No resume window exists until power-down has been released once. A stop release after reset resumes within the synchronizer latency plus one source-clock low phase.
- R11: While power-down is active or its window is open, `cfg_pdn_tri` chooses tristate or driven. Otherwise a stop request uses `cfg_stop_tri`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| pdn_req_n | input | 1 | Asynchronous active-low power-down request |
| cfg_stop_tri | input | 1 | 1: stop request tristates the group, 0: drives it parked |
| cfg_pdn_tri | input | 1 | 1: power-down tristates the group, 0: drives it parked |
| src_clk_i | input | N_OUT | Level of each stoppable output's source clock |
| run_o | output | N_OUT | Per-output toggle enable |
| hiz_o | output | N_OUT | Per-output tristate control |
| true_o | output | N_OUT | Gated true clock level |
| comp_o | output | N_OUT | Gated complement clock level |
| free_en_o | output | N_FREE | Enables of the free-running outputs, always on |

## Verification
The stop request is applied alone, with driven and then with tristate configuration. Comparing the two shows that the configuration selects the stopped state. Power-down is applied alone, together with an active stop, and with the stop released partway through the resume window. These patterns separate a correct window length from an early resume, and show whether a late stop release adds delay. Configuration bits are changed inside the window. A visible change before the window closes means the hold is missing, and a stale value after it means the held change was lost. The two source clocks use different periods, so the low-phase alignment of each output is checked separately.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

   // effective stop configuration, 1 = tristate, 0 = driven parked
   typedef struct packed {
      logic stop_tri;
      logic pdn_tri;
   } cs_cfg_t;

   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cs_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("cs_sync: W must be at least 1");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cs_resume_timer.sv
module cs_resume_timer #(
   parameter int RESUME_CYC = 450000,
   parameter int CW         = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pdn_act_i,
   output logic          hold_o,
   output logic          win_o,
   output logic [CW-1:0] cnt_o
);

   localparam logic [CW-1:0] LOAD = CW'(RESUME_CYC);

   if (RESUME_CYC < 1) begin : g_bad_len
      $error("cs_resume_timer: RESUME_CYC must be at least 1");
   end
   if ((2 ** CW) <= RESUME_CYC) begin : g_bad_cw
      $error("cs_resume_timer: CW too narrow for RESUME_CYC");
   end

   logic          pdn_q;
   logic [CW-1:0] cnt_q;
   logic          release_edge;

   assign release_edge = pdn_q & ~pdn_act_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pdn_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         pdn_q <= pdn_act_i;
         if (pdn_act_i)              cnt_q <= '0;
         else if (release_edge)      cnt_q <= LOAD;
         else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
      end
   end

   assign win_o  = (cnt_q != '0);
   // power-down in force: request, the release cycle, or the window
   assign hold_o = pdn_act_i | pdn_q | win_o;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/cs_out_gate.sv
module cs_out_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic stop_i,
   input  logic tri_i,
   output logic run_o,
   output logic hiz_o,
   output logic true_o,
   output logic comp_o
);

   logic run_q;
   logic hiz_q;

   // state moves only while the source clock is low: no runt pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1;
         hiz_q <= 1'b0;
      end else if (!src_i) begin
         run_q <= ~stop_i;
         hiz_q <= stop_i & tri_i;
      end
   end

   assign run_o  = run_q;
   assign hiz_o  = hiz_q;
   assign true_o = run_q & src_i;
   assign comp_o = run_q ? ~src_i : 1'b1;

endmodule

// File: rtl/clk_stop_ctl.sv
module clk_stop_ctl
   import clk_stop_pkg::*;
#(
   parameter int N_OUT       = 4,
   parameter int N_FREE      = 3,
   parameter int RESUME_CYC  = 450000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req_n,
   input  logic              pdn_req_n,
   input  logic              cfg_stop_tri,
   input  logic              cfg_pdn_tri,
   input  logic [N_OUT-1:0]  src_clk_i,
   output logic [N_OUT-1:0]  run_o,
   output logic [N_OUT-1:0]  hiz_o,
   output logic [N_OUT-1:0]  true_o,
   output logic [N_OUT-1:0]  comp_o,
   output logic [N_FREE-1:0] free_en_o
);

   localparam int CW = cnt_w(RESUME_CYC);

   if (N_OUT < 1) begin : g_bad_nout
      $error("clk_stop_ctl: N_OUT must be at least 1");
   end
   if (N_FREE < 1) begin : g_bad_nfree
      $error("clk_stop_ctl: N_FREE must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clk_stop_ctl: SYNC_STAGES must be at least 2");
   end

   logic [1:0]    raw_n;
   logic [1:0]    sync_n;
   logic          stop_act;
   logic          pdn_act;
   logic          pd_hold;
   logic          win;
   logic [CW-1:0] win_cnt;
   cs_cfg_t       cfg_eff;
   logic          stop_any;
   logic          tri_sel;

   assign raw_n = {stop_req_n, pdn_req_n};

   cs_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_n),
      .q_o   (sync_n)
   );

   assign stop_act = ~sync_n[1];
   assign pdn_act  = ~sync_n[0];

   cs_resume_timer #(
      .RESUME_CYC (RESUME_CYC),
      .CW         (CW)
   ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .pdn_act_i (pdn_act),
      .hold_o    (pd_hold),
      .win_o     (win),
      .cnt_o     (win_cnt)
   );

   // configuration is frozen while the resume window is open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_eff <= '0;
      end else if (!win) begin
         cfg_eff.stop_tri <= cfg_stop_tri;
         cfg_eff.pdn_tri  <= cfg_pdn_tri;
      end
   end

   assign stop_any = pd_hold | stop_act;
   assign tri_sel  = pd_hold ? cfg_eff.pdn_tri : cfg_eff.stop_tri;

   for (genvar g = 0; g < N_OUT; g++) begin : g_out
      cs_out_gate u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .src_i  (src_clk_i[g]),
         .stop_i (stop_any),
         .tri_i  (tri_sel),
         .run_o  (run_o[g]),
         .hiz_o  (hiz_o[g]),
         .true_o (true_o[g]),
         .comp_o (comp_o[g])
      );
   end

   for (genvar f = 0; f < N_FREE; f++) begin : g_free
      assign free_en_o[f] = 1'b1;
   end

endmodule

// File: rtl/clk_stop_chk.sv
module clk_stop_chk #(
   parameter int N_OUT      = 4,
   parameter int CW         = 19,
   parameter int RESUME_CYC = 450000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop_req_n,
   input logic             pdn_req_n,
   input logic [N_OUT-1:0] src_clk_i,
   input logic [N_OUT-1:0] run_o,
   input logic [N_OUT-1:0] hiz_o,
   input logic             stop_act,
   input logic             pdn_act,
   input logic             pd_hold,
   input logic             win,
   input logic [CW-1:0]    win_cnt,
   input logic [1:0]       cfg_eff
);

   AST_SYNC_STOP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_act) |-> $past(!stop_req_n, 2)); // R8

   AST_SYNC_PDN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdn_act) |-> $past(!pdn_req_n, 2)); // R8

   AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdn_act) |=> (win_cnt == CW'(RESUME_CYC))); // R5

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      win |=> $stable(cfg_eff)); // R7

   for (genvar i = 0; i < N_OUT; i++) begin : g_chk
      AST_RESUME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(run_o[i]) |-> (!$past(pd_hold) && !$past(stop_act))); // R6

      AST_RUN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(run_o[i]) |-> !$past(src_clk_i[i])); // R9

      AST_HIZ_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(hiz_o[i]) |-> !$past(src_clk_i[i])); // R9

      AST_HIZ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(hiz_o[i]) |-> $past(pd_hold ? cfg_eff[0] : (stop_act && cfg_eff[1]))); // R11
   end

endmodule

bind clk_stop_ctl clk_stop_chk #(
   .N_OUT      (N_OUT),
   .CW         (CW),
   .RESUME_CYC (RESUME_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_req_n (stop_req_n),
   .pdn_req_n  (pdn_req_n),
   .src_clk_i  (src_clk_i),
   .run_o      (run_o),
   .hiz_o      (hiz_o),
   .stop_act   (stop_act),
   .pdn_act    (pdn_act),
   .pd_hold    (pd_hold),
   .win        (win),
   .win_cnt    (win_cnt),
   .cfg_eff    (cfg_eff)
);

// File: tb/sim_clk_stop_ctl.sv
module sim_clk_stop_ctl;

   localparam int N_OUT  = 2;
   localparam int N_FREE = 2;
   localparam int RCYC   = 20;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n        = 1'b0;
   logic              stop_req_n   = 1'b1;
   logic              pdn_req_n    = 1'b1;
   logic              cfg_stop_tri = 1'b0;
   logic              cfg_pdn_tri  = 1'b0;
   logic [N_OUT-1:0]  src_clk      = '0;
   logic [N_OUT-1:0]  run_o, hiz_o, true_o, comp_o;
   logic [N_FREE-1:0] free_en_o;

   int  vec_cnt = 0;
   int  err_cnt = 0;
   bit  done    = 0;

   typedef struct {
      string req;
      bit    run;
      bit    hiz;
   } exp_t;

   exp_t sb_q[$];

   clk_stop_ctl #(
      .N_OUT      (N_OUT),
      .N_FREE     (N_FREE),
      .RESUME_CYC (RCYC)
   ) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_req_n   (stop_req_n),
      .pdn_req_n    (pdn_req_n),
      .cfg_stop_tri (cfg_stop_tri),
      .cfg_pdn_tri  (cfg_pdn_tri),
      .src_clk_i    (src_clk),
      .run_o        (run_o),
      .hiz_o        (hiz_o),
      .true_o       (true_o),
      .comp_o       (comp_o),
      .free_en_o    (free_en_o)
   );

   // two source clocks of different period: 4 and 6 reference cycles
   int div0 = 0;
   int div1 = 0;
   always @(negedge clk) begin
      div0 = div0 + 1;
      div1 = div1 + 1;
      if (div0 == 2) begin div0 = 0; src_clk[0] = ~src_clk[0]; end
      if (div1 == 3) begin div1 = 0; src_clk[1] = ~src_clk[1]; end
   end

   task automatic expect_st(input string req, input bit run, input bit hiz);
      exp_t e;
      e.req = req;
      e.run = run;
      e.hiz = hiz;
      sb_q.push_back(e);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
   endtask

   // monitor: phase alignment on every sample, scoreboard items when queued
   initial begin
      logic [N_OUT-1:0] prev_run;
      bit               have_prev;
      have_prev = 0;
      prev_run  = '0;
      forever begin
         exp_t e;
         logic [N_OUT-1:0] et, ec;
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (have_prev) begin
               for (int i = 0; i < N_OUT; i++) begin
                  if (run_o[i] !== prev_run[i]) begin
                     vec_cnt++;
                     if (src_clk[i] !== 1'b0) begin
                        err_cnt++;
                        $display("FAIL R9 output %0d switched with source high: src=%b expected 0", i, src_clk[i]);
                     end
                  end
               end
            end
            prev_run  = run_o;
            have_prev = 1;
         end
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            for (int i = 0; i < N_OUT; i++) begin
               et[i] = e.run ? src_clk[i] : 1'b0;
               ec[i] = e.run ? ~src_clk[i] : 1'b1;
            end
            vec_cnt++;
            if (run_o !== {N_OUT{e.run}} || hiz_o !== {N_OUT{e.hiz}} ||
                (!e.hiz && (true_o !== et || comp_o !== ec))) begin
               err_cnt++;
               $display("FAIL %s: run=%b hiz=%b true=%b comp=%b expected run=%b hiz=%b true=%b comp=%b",
                        e.req, run_o, hiz_o, true_o, comp_o,
                        {N_OUT{e.run}}, {N_OUT{e.hiz}}, et, ec);
            end
            vec_cnt++;
            if (free_en_o !== {N_FREE{1'b1}}) begin
               err_cnt++;
               $display("FAIL R4 free-running enables (%s): actual=%b expected=%b",
                        e.req, free_en_o, {N_FREE{1'b1}});
            end
         end
      end
   end

   // driver
   initial begin
      step(3);
      @(negedge clk) rst_n = 1'b1;
      step(1);
      expect_st("R1 reset state", 1, 0);

      // R8 then R2: stop with driven configuration
      @(negedge clk) stop_req_n = 1'b0;
      step(2);
      expect_st("R8 no effect before third edge", 1, 0);
      step(10);
      expect_st("R2 stop parks driven", 0, 0);

      // R10: no window armed before any power-down
      @(negedge clk) stop_req_n = 1'b1;
      step(10);
      expect_st("R10 prompt resume after reset", 1, 0);

      // R3: both tristate bits set
      @(negedge clk) begin cfg_stop_tri = 1'b1; cfg_pdn_tri = 1'b1; end
      step(2);
      @(negedge clk) stop_req_n = 1'b0;
      step(10);
      expect_st("R3 stop tristates", 0, 1);
      @(negedge clk) stop_req_n = 1'b1;
      step(10);
      expect_st("R3 stop released", 1, 0);
      @(negedge clk) pdn_req_n = 1'b0;
      step(10);
      expect_st("R3 power-down tristates", 0, 1);

      // R5: window length
      @(negedge clk) pdn_req_n = 1'b1;
      step(RCYC + 3);
      expect_st("R5 still stopped at window end", 0, 1);
      step(4);
      expect_st("R5 resumed after window", 1, 0);

      // R11: power-down selects its own configuration bit
      @(negedge clk) begin cfg_stop_tri = 1'b0; cfg_pdn_tri = 1'b1; end
      step(2);
      @(negedge clk) begin stop_req_n = 1'b0; pdn_req_n = 1'b0; end
      step(10);
      expect_st("R11 power-down uses its bit", 0, 1);
      @(negedge clk) pdn_req_n = 1'b1;
      step(RCYC + 7);
      expect_st("R11 stop uses its bit after window", 0, 0);

      // R6: stop released inside the window
      @(negedge clk) begin cfg_stop_tri = 1'b0; cfg_pdn_tri = 1'b0; end
      step(2);
      @(negedge clk) pdn_req_n = 1'b0;
      step(10);
      expect_st("R6 setup power-down driven", 0, 0);
      @(negedge clk) pdn_req_n = 1'b1;
      step(5);
      @(negedge clk) stop_req_n = 1'b1;
      step(RCYC - 2);
      expect_st("R6 held until window end", 0, 0);
      step(4);
      expect_st("R6 resumed at window end", 1, 0);

      // R7: configuration change inside the window is held
      @(negedge clk) begin cfg_stop_tri = 1'b1; cfg_pdn_tri = 1'b1; end
      step(2);
      @(negedge clk) pdn_req_n = 1'b0;
      step(10);
      expect_st("R7 setup power-down tristate", 0, 1);
      @(negedge clk) pdn_req_n = 1'b1;
      step(8);
      @(negedge clk) cfg_pdn_tri = 1'b0;
      step(5);
      expect_st("R7 change held inside window", 0, 1);
      step(RCYC);
      expect_st("R7 running after window", 1, 0);

      // R7: held change applied once the window ends
      @(negedge clk) pdn_req_n = 1'b0;
      step(10);
      expect_st("R7 setup power-down driven", 0, 0);
      @(negedge clk) begin pdn_req_n = 1'b1; stop_req_n = 1'b0; end
      step(6);
      @(negedge clk) cfg_stop_tri = 1'b0;
      step(RCYC + 5);
      expect_st("R7 held stop bit applied after window", 0, 0);

      @(negedge clk) stop_req_n = 1'b1;
      step(10);
      expect_st("R10 final resume", 1, 0);
      step(3);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         err_cnt++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule